// File: doc/BRIEF.md
# Scratchpad Partitioning Memory Controller

This controller shares one backing memory among a fixed set of clients. Each client works in a private address space that starts at zero. At start-up each client sends one allocation request carrying its dense client ID and the number of words it needs. The controller hands out regions back to back, beginning at physical word 0, and records a base offset and a size for each ID. A request that does not fit in the memory that is left is refused, and a sticky error flag is raised.

Once every ID has had its allocation handled, the controller opens its data port. Each tagged write or read is range-checked against the region of its ID and rebased by adding the ID's base offset. A request that passes the check goes out on a simple backing-memory port. A read or write for an ID with no region, or for an address outside the region, never reaches memory and produces an error response instead. Read data and error responses return in the order the requests were accepted, each tagged with the originating ID. A small queue holds those responses while they wait.

Top module: `spad_part_ctrl`

## Requirements
- R1: After reset, alloc_done and alloc_err are 0, alloc_ready is 1, and rsp_valid is 0.
- R2: Granted allocations receive consecutive regions in the order they are granted. The first starts at physical word 0, and each later one starts where the previous granted region ends. A forwarded request's mem_addr equals the base of its ID plus its private address.
- R3: A second allocation request for an ID that was already handled is ignored. Its base and size remain as first set, and the regions granted later are unaffected.
- R4: An allocation whose end would pass MEM_WORDS is refused. alloc_err goes to 1 and stays there, the ID stays without a region, and the free pointer does not move. A region that ends exactly at MEM_WORDS is granted.
- R5: alloc_done goes to 1 once every ID from 0 to NUM_ID-1 has had one allocation handled, whether granted or refused. It stays at 1, and alloc_ready is 0 from then on.
- R6: While alloc_done is 0, req_ready is 0 and mem_valid is 0.
- R7: A write (req_we=1) that is in range is forwarded with mem_we=1, the translated mem_addr and the write data. It produces no response.
- R8: A read that is in range is forwarded with mem_we=0. Its response carries rsp_err=0, the requesting ID and the word the backing memory returns. A read is not accepted while mem_ready is 0.
- R9: A request whose ID has no region, or whose private address is not below the region size, is accepted without asserting mem_valid. It produces one response with rsp_err=1, the requesting ID and rsp_data=0.
- R10: Responses leave in acceptance order, with reads and errors interleaved. When DEPTH responses are waiting or in flight, any read or rejected request is held off with req_ready=0 and is not forwarded.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays at 1 and rsp_id, rsp_err and rsp_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Allocation accepted (high until all IDs handled) |
| alloc_id | input | IDW | Client ID of the allocation |
| alloc_size | input | PAW+1 | Words requested |
| alloc_done | output | 1 | Every ID has been handled |
| alloc_err | output | 1 | Sticky: some allocation did not fit |
| req_valid | input | 1 | Data request present |
| req_ready | output | 1 | Data request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_id | input | IDW | Client ID of the request |
| req_addr | input | AW | Private, zero-based word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_id | output | IDW | ID of the request answered |
| rsp_err | output | 1 | Request was rejected |
| rsp_data | output | DW | Read data (0 on error) |
| mem_valid | output | 1 | Backing-memory request |
| mem_ready | input | 1 | Backing memory takes the request |
| mem_we | output | 1 | Backing-memory write enable |
| mem_addr | output | PAW | Physical word address |
| mem_wdata | output | DW | Backing-memory write data |
| mem_rvalid | input | 1 | Read data returning, in request order |
| mem_rdata | input | DW | Read data |

## Verification
The assertions check the following on every cycle: alloc_done and alloc_err never fall once set; nothing is accepted or forwarded before allocation closes; a forwarded request always stems from a live client request; a read is not taken while memory stalls; and a response stalled by rsp_ready holds still. The bench scenarios alone can show that the regions are correct. That covers the base values from consecutive allocation, the refusal that leaves the free pointer in place, the exact-fit boundary, and the ignored repeat. Only the scenarios can also show the address rebasing per ID, the matching of returned data and errors to their requests in order, and the hold-off when the queue is full.

// File: rtl/spad_part_ctrl.sv
module spad_part_ctrl #(
  parameter int NUM_ID    = 4,
  parameter int MEM_WORDS = 256,
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int DEPTH     = 4,
  localparam int IDW = (NUM_ID > 1) ? $clog2(NUM_ID) : 1,
  localparam int PAW = $clog2(MEM_WORDS),
  localparam int SW  = PAW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  output logic           alloc_ready,
  input  logic [IDW-1:0] alloc_id,
  input  logic [SW-1:0]  alloc_size,
  output logic           alloc_done,
  output logic           alloc_err,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_we,
  input  logic [IDW-1:0] req_id,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [IDW-1:0] rsp_id,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [PAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = (AW > SW) ? AW : SW;
  localparam logic [SW:0] CAP = (SW+1)'(MEM_WORDS);

  logic [PAW-1:0] base [NUM_ID];
  logic [SW-1:0]  rsize [NUM_ID];
  logic [NUM_ID-1:0] granted, seen;
  logic [SW-1:0]  next_free;
  logic [SW:0]    end_pos;

  assign alloc_done  = &seen;
  assign alloc_ready = !alloc_done;
  assign end_pos     = {1'b0, next_free} + {1'b0, alloc_size};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      granted   <= '0;
      seen      <= '0;
      next_free <= '0;
      alloc_err <= 1'b0;
      for (int i = 0; i < NUM_ID; i++) begin
        base[i]  <= '0;
        rsize[i] <= '0;
      end
    end else if (alloc_valid && !alloc_done && (int'(alloc_id) < NUM_ID) && !seen[alloc_id]) begin
      seen[alloc_id] <= 1'b1;
      if (end_pos > CAP) begin
        alloc_err <= 1'b1;
      end else begin
        granted[alloc_id] <= 1'b1;
        base[alloc_id]    <= next_free[PAW-1:0];
        rsize[alloc_id]   <= alloc_size;
        next_free         <= end_pos[SW-1:0];
      end
    end
  end

  logic [IDW-1:0] q_id   [DEPTH];
  logic [DW-1:0]  q_data [DEPTH];
  logic [DEPTH-1:0] q_err, q_pend;
  logic [PW-1:0]  wp, rp, fsel;
  logic [PW:0]    cnt;
  logic hit, need_slot, full, push, pop;

  assign hit       = (int'(req_id) < NUM_ID) && granted[req_id] &&
                     (CW'(req_addr) < CW'(rsize[req_id]));
  assign need_slot = !req_we || !hit;
  assign full      = (cnt == (PW+1)'(DEPTH));
  assign req_ready = alloc_done && !(need_slot && full) && !(hit && !mem_ready);
  assign mem_valid = req_valid && alloc_done && hit && (req_we || !full);
  assign mem_we    = req_we;
  assign mem_addr  = base[req_id] + PAW'(req_addr);
  assign mem_wdata = req_wdata;

  assign push      = req_valid && req_ready && need_slot;
  assign rsp_valid = (cnt != '0) && !q_pend[rp];
  assign pop       = rsp_valid && rsp_ready;
  assign rsp_id    = q_id[rp];
  assign rsp_err   = q_err[rp];
  assign rsp_data  = q_data[rp];

  always_comb begin
    fsel = rp;
    for (int k = DEPTH-1; k >= 0; k--)
      if ((PW+1)'(k) < cnt && q_pend[rp + PW'(k)]) fsel = rp + PW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      q_err <= '0;
      q_pend <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_id[i]   <= '0;
        q_data[i] <= '0;
      end
    end else begin
      if (mem_rvalid) begin
        q_data[fsel] <= mem_rdata;
        q_pend[fsel] <= 1'b0;
      end
      if (push) begin
        q_id[wp]   <= req_id;
        q_err[wp]  <= !hit;
        q_pend[wp] <= hit;
        q_data[wp] <= '0;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end
endmodule

// File: rtl/spad_part_ctrl_chk.sv
module spad_part_ctrl_chk #(
  parameter int IDW = 2,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alloc_done,
  input logic           alloc_ready,
  input logic           alloc_err,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_we,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [IDW-1:0] rsp_id,
  input logic           rsp_err,
  input logic [DW-1:0]  rsp_data
);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> alloc_done);
  p_alloc_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> !alloc_ready);
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err);
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_done |-> (!mem_valid && !req_ready));
  p_fwd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> req_valid);
  p_read_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !req_we && !mem_ready) |-> !req_ready);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_err) && $stable(rsp_data)));
endmodule

bind spad_part_ctrl spad_part_ctrl_chk #(.IDW(IDW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_done(alloc_done), .alloc_ready(alloc_ready),
  .alloc_err(alloc_err), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_err(rsp_err), .rsp_data(rsp_data)
);

// File: tb/tb_spad_part_ctrl.sv
`timescale 1ns/1ps
module tb_spad_part_ctrl;
  localparam int NUM_ID = 4, MEM_WORDS = 256, AW = 8, DW = 16, DEPTH = 4;
  localparam int IDW = 2, PAW = 8, SW = 9;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic alloc_valid = 0, alloc_ready, alloc_done, alloc_err;
  logic [IDW-1:0] alloc_id = 0;
  logic [SW-1:0]  alloc_size = 0;
  logic req_valid = 0, req_ready, req_we = 0;
  logic [IDW-1:0] req_id = 0;
  logic [AW-1:0]  req_addr = 0;
  logic [DW-1:0]  req_wdata = 0;
  logic rsp_valid, rsp_ready = 0, rsp_err;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0]  rsp_data;
  logic mem_valid, mem_ready = 0, mem_we, mem_rvalid;
  logic [PAW-1:0] mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata;

  spad_part_ctrl #(.NUM_ID(NUM_ID), .MEM_WORDS(MEM_WORDS), .AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_id(alloc_id), .alloc_size(alloc_size), .alloc_done(alloc_done), .alloc_err(alloc_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_id(req_id),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_id(rsp_id), .rsp_err(rsp_err), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // backing memory: in-order reads, two cycles of latency
  logic [DW-1:0] bmem [MEM_WORDS];
  logic [DW-1:0] shadow [MEM_WORDS];
  logic rv1, rv2;
  logic [DW-1:0] rd1, rd2;
  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 7 + 3);
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) bmem[i] <= init_word(i);
      rv1 <= 0; rv2 <= 0; rd1 <= 0; rd2 <= 0;
    end else begin
      if (mem_valid && mem_ready && mem_we) bmem[mem_addr] <= mem_wdata;
      rv1 <= mem_valid && mem_ready && !mem_we;
      rd1 <= bmem[mem_addr];
      rv2 <= rv1;
      rd2 <= rd1;
    end
  end
  assign mem_rvalid = rv2;
  assign mem_rdata  = rd2;

  // expected region model
  int eb [NUM_ID], esz [NUM_ID];
  bit egr [NUM_ID];
  int x_id [$], x_err [$], x_data [$];
  bit hold_rsp = 0;

  task automatic send(input bit we, input int id, input int addr, input logic [DW-1:0] d);
    bit hit;
    int ph;
    hit = egr[id] && addr < esz[id];
    ph = eb[id] + addr;
    @(negedge clk);
    req_valid = 1; req_we = we; req_id = IDW'(id); req_addr = AW'(addr); req_wdata = d;
    forever begin
      #1;
      if (req_ready) begin
        if (hit) begin
          chk(mem_valid === 1'b1, we ? "R7 write forwarded" : "R8 read forwarded", int'(mem_valid), 1);
          chk(mem_addr === PAW'(ph), "R2 translated address", int'(mem_addr), ph);
          chk(mem_we === we, "R7 mem_we", int'(mem_we), int'(we));
          if (we) chk(mem_wdata === d, "R7 write data", int'(mem_wdata), int'(d));
        end else begin
          chk(mem_valid === 1'b0, "R9 rejected not forwarded", int'(mem_valid), 0);
        end
        if (!hit) begin x_id.push_back(id); x_err.push_back(1); x_data.push_back(0); end
        else if (!we) begin x_id.push_back(id); x_err.push_back(0); x_data.push_back(int'(shadow[ph])); end
        else shadow[ph] = d;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid = 0;
  endtask

  // response side and memory ready
  bit p_stall = 0;
  int p_id = 0, p_err = 0, p_data = 0;
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = hold_rsp ? 1'b0 : ($urandom % 4 != 0);
      mem_ready = ($urandom % 4 != 0);
      #2;
      if (rst_n && p_stall)
        chk(rsp_valid === 1'b1 && int'(rsp_id) == p_id && int'(rsp_err) == p_err && int'(rsp_data) == p_data,
            "R11 response held", int'(rsp_data), p_data);
      p_stall = rst_n && rsp_valid && !rsp_ready;
      p_id = int'(rsp_id); p_err = int'(rsp_err); p_data = int'(rsp_data);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (x_id.size() == 0) chk(0, "R10 unexpected response", int'(rsp_id), -1);
        else begin
          chk(int'(rsp_id) == x_id[0], "R10 response order id", int'(rsp_id), x_id[0]);
          chk(int'(rsp_err) == x_err[0], x_err[0] ? "R9 error flag" : "R8 error flag", int'(rsp_err), x_err[0]);
          chk(int'(rsp_data) == x_data[0], x_err[0] ? "R9 error data" : "R8 read data", int'(rsp_data), x_data[0]);
          void'(x_id.pop_front()); void'(x_err.pop_front()); void'(x_data.pop_front());
        end
      end
    end
  end

  task automatic do_alloc(input int id, input int sz);
    @(negedge clk);
    alloc_valid = 1; alloc_id = IDW'(id); alloc_size = SW'(sz);
    @(posedge clk);
    #1 alloc_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < MEM_WORDS; i++) shadow[i] = init_word(i);
    for (int i = 0; i < NUM_ID; i++) begin eb[i] = 0; esz[i] = 0; egr[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(alloc_done === 0 && alloc_err === 0, "R1 reset flags", int'(alloc_done), 0);
    chk(alloc_ready === 1, "R1 alloc_ready", int'(alloc_ready), 1);
    chk(rsp_valid === 0, "R1 rsp_valid", int'(rsp_valid), 0);

    // data request before allocation closes
    req_valid = 1; req_we = 0; req_id = 2; req_addr = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(req_ready === 0 && mem_valid === 0, "R6 gated before done", int'(req_ready), 0);
    end
    req_valid = 0;

    do_alloc(2, 100); eb[2] = 0;   esz[2] = 100; egr[2] = 1;
    do_alloc(0, 60);  eb[0] = 100; esz[0] = 60;  egr[0] = 1;
    do_alloc(2, 10);  // R3 repeat ignored
    do_alloc(3, 120); // R4 does not fit: 160 + 120 > 256
    @(negedge clk); #1;
    chk(alloc_err === 1, "R4 overflow flag", int'(alloc_err), 1);
    chk(alloc_done === 0, "R5 not yet done", int'(alloc_done), 0);
    do_alloc(1, 96);  eb[1] = 160; esz[1] = 96;  egr[1] = 1;  // ends exactly at 256
    @(negedge clk); #1;
    chk(alloc_done === 1, "R5 done after all IDs", int'(alloc_done), 1);
    chk(alloc_ready === 0, "R5 alloc_ready low", int'(alloc_ready), 0);
    chk(alloc_err === 1, "R4 flag sticky", int'(alloc_err), 1);
    do_alloc(0, 5);   // after done: ignored

    send(1, 1, 95, 16'hbeef);   // R4 exact-fit region, last word -> 255
    send(0, 1, 95, 0);
    send(0, 1, 96, 0);          // R9 out of range
    send(0, 3, 0, 0);           // R9 refused ID
    send(0, 0, 0, 0);           // R3: base of ID 0 still 100
    send(1, 2, 99, 16'h1234);   // R3: size of ID 2 still 100
    send(0, 2, 99, 0);
    send(0, 0, 60, 0);          // R9 first word past region

    // R10 fill the response queue
    wait (x_id.size() == 0);
    hold_rsp = 1;
    for (int i = 0; i < DEPTH; i++) send(0, 2, i, 0);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_id = 0; req_addr = 1;
    for (int c = 0; c < 3; c++) begin
      #1 chk(req_ready === 0 && mem_valid === 0, "R10 held off when full", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
    hold_rsp = 0;
    send(0, 0, 1, 0);

    // random mix
    for (int n = 0; n < 400; n++)
      send(bit'($urandom % 2), int'($urandom % NUM_ID), int'($urandom % 128), DW'($urandom));

    wait (x_id.size() == 0);
    repeat (4) @(negedge clk);
    #1 chk(rsp_valid === 0, "R10 no extra response", int'(rsp_valid), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule